// File: doc/BRIEF.md
# BPSK Burst BER Test Controller

This block measures the bit error rate of one burst of recovered BPSK bits each time software asks for it. Software sets three run parameters: how many valid bits to discard after launch, how many compared bits make up the frame, and how many of those leading bits belong to the preamble. It then raises a start request. The request comes from a separate control clock domain and is synchronized inside the block. A run is launched only on a rising edge of the synchronized request.

While a run is active, the block takes each recovered bit on its valid strobe. Once the offset is used up, it compares the bit with the expected reference bit that arrives on the same strobe. It counts the bits received, all mismatches, and the mismatches that fall after the preamble. The run ends when the frame is complete. It also ends when the bit stream goes quiet for a set number of cycles, and in that case a sticky timeout flag is raised along with done. A fixed signature word lets software confirm the block is present before it programs a run.

Top module: `ber_burst_ctrl`

## Requirements
- R1: A run is launched only by a rising edge of control bit 0 after its two-flop synchronizer, so busy rises on the third clock edge after the request goes high. Holding the request high does not launch another run after the first one ends.
- R2: The status word has the synchronized start level in bit 0, busy in bit 1, sticky done in bit 2 and the sticky timeout flag in bit 3.
- R3: After a launch, the first `skip_len` valid bits are discarded. They are neither counted nor compared.
- R4: Every later valid bit increments `rx_count` until it equals `frame_len`. On the next clock, busy clears and done is set, and valid bits arriving after that change no counter.
- R5: `err_total` counts every compared bit whose data differs from the reference bit. `err_payload` counts only the mismatches whose compared-bit index (counted from 0) is at least `pre_len`.
- R6: While busy, `TIMEOUT_CYCLES` consecutive clocks without a valid strobe abort the run. The abort clears busy, sets done and the timeout flag, and leaves `rx_count` at the number of bits collected.
- R7: Control bit 1, after synchronization, clears both sticky done and the timeout flag while no run is active.
- R8: A start edge while busy is ignored. An accepted start zeroes all three counters and both sticky flags.
- R9: The `signature` output always reads 0x4250534B.
- R10: After reset, the status word and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-stream clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 2 | Bit 0 start request, bit 1 clear sticky flags (from the control clock domain) |
| frame_len | input | CNT_W | Number of bits to compare per run |
| pre_len | input | CNT_W | Number of leading compared bits that form the preamble |
| skip_len | input | CNT_W | Number of valid bits to discard after launch |
| bit_valid | input | 1 | Strobe marking a recovered bit |
| bit_data | input | 1 | Recovered bit |
| ref_bit | input | 1 | Expected bit, aligned with bit_valid |
| status_word | output | 4 | {timeout, done, busy, synchronized start level} |
| rx_count | output | CNT_W | Bits compared in the current or last run |
| err_total | output | CNT_W | Mismatches over all compared bits |
| err_payload | output | CNT_W | Mismatches after the preamble |
| signature | output | 32 | Fixed identification value |

## Verification
The hardest case to reach from the ports is a start edge that lands in the middle of an active run. The synchronized request has to fall and rise again while bits are still being collected. The bench gets there by sending half a frame, toggling the request through the synchronizer with waits long enough for the edge to register, and then sending the rest of the frame. A launch that was wrongly accepted would show up as a short `rx_count`. The timeout path is driven the same way: a few bits are sent and the stream then stops. The bench checks that busy is still set before the limit and that the abort has happened after it.

// File: rtl/ber_burst_pkg.sv
// Package: shared constants for the BPSK burst BER test controller.
// Assumes: nothing beyond the standard language.
package ber_burst_pkg;
    localparam logic [31:0] BBC_SIGNATURE = 32'h4250534B;
    localparam int ST_START_LVL = 0;
    localparam int ST_BUSY      = 1;
    localparam int ST_DONE      = 2;
    localparam int ST_TIMEOUT   = 3;
endpackage

// File: rtl/bbc_sync.sv
// Module: two-flop level synchronizer for control bits crossing in from the
// control clock domain.
// Assumes: each bit is quasi-static; the bits are not sampled as a coherent group.
module bbc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl
);
    logic [W-1:0] meta_q;

    // Purpose: two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl    <= '0;
        end else begin
            meta_q <= async_in;
            lvl    <= meta_q;
        end
    end
endmodule

// File: rtl/bbc_idle_timer.sv
// Module: counts consecutive cycles with no valid strobe while a run is active,
// and flags the cycle in which the limit is reached.
// Assumes: LIMIT >= 1; the counter is restarted at each launch.
module bbc_idle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic strobe,
    output logic expire
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] idle_q;

    // Purpose: count idle cycles; any strobe, restart or idle state clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || strobe || !run) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign expire = run && !strobe && (idle_q == TW'(LIMIT - 1));
endmodule

// File: rtl/bbc_core.sv
// Module: run sequencer and counters. Detects the start edge, skips the
// offset, compares bits, splits errors into total and payload, ends the run
// on a full frame or on timeout, and holds the sticky flags.
// Assumes: run parameters stay stable while busy; ref_bit is aligned with bit_valid.
module bbc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_lvl,
    input  logic             clear_lvl,
    input  logic             expire,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             ref_bit,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] pre_len,
    input  logic [CNT_W-1:0] skip_len,
    output logic             launch,
    output logic             busy,
    output logic             done,
    output logic             tmo,
    output logic [CNT_W-1:0] rx_count,
    output logic [CNT_W-1:0] err_total,
    output logic [CNT_W-1:0] err_payload
);
    logic             start_prev_q;
    logic [CNT_W-1:0] skip_q;
    logic             mismatch;

    assign launch   = start_lvl && !start_prev_q && !busy;
    assign mismatch = bit_data ^ ref_bit;

    // Purpose: remember the previous synchronized start level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_prev_q <= 1'b0;
        else        start_prev_q <= start_lvl;
    end

    // Purpose: run state machine, counters and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            tmo         <= 1'b0;
            skip_q      <= '0;
            rx_count    <= '0;
            err_total   <= '0;
            err_payload <= '0;
        end else if (launch) begin
            busy        <= 1'b1;
            done        <= 1'b0;
            tmo         <= 1'b0;
            skip_q      <= '0;
            rx_count    <= '0;
            err_total   <= '0;
            err_payload <= '0;
        end else if (busy) begin
            if (rx_count == frame_len) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (bit_valid) begin
                if (skip_q < skip_len) begin
                    skip_q <= skip_q + 1'b1;
                end else begin
                    rx_count <= rx_count + 1'b1;
                    if (mismatch) begin
                        err_total <= err_total + 1'b1;
                        if (rx_count >= pre_len) err_payload <= err_payload + 1'b1;
                    end
                end
            end else if (expire) begin
                busy <= 1'b0;
                done <= 1'b1;
                tmo  <= 1'b1;
            end
        end else if (clear_lvl) begin
            done <= 1'b0;
            tmo  <= 1'b0;
        end
    end
endmodule

// File: rtl/ber_burst_ctrl.sv
// Module: top of the BPSK burst BER test controller. Synchronizes the control
// word, runs one measurement per start edge and packs the status word.
// Assumes: ctrl_word comes from another clock domain and is held for several cycles.
module ber_burst_ctrl
    import ber_burst_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ctrl_word,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] pre_len,
    input  logic [CNT_W-1:0] skip_len,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             ref_bit,
    output logic [3:0]       status_word,
    output logic [CNT_W-1:0] rx_count,
    output logic [CNT_W-1:0] err_total,
    output logic [CNT_W-1:0] err_payload,
    output logic [31:0]      signature
);
    logic [1:0] ctrl_sync;
    logic       launch;
    logic       busy;
    logic       done;
    logic       tmo;
    logic       expire;

    bbc_sync #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctrl_word),
        .lvl      (ctrl_sync)
    );

    bbc_idle_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (launch),
        .strobe  (bit_valid),
        .expire  (expire)
    );

    bbc_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_lvl   (ctrl_sync[0]),
        .clear_lvl   (ctrl_sync[1]),
        .expire      (expire),
        .bit_valid   (bit_valid),
        .bit_data    (bit_data),
        .ref_bit     (ref_bit),
        .frame_len   (frame_len),
        .pre_len     (pre_len),
        .skip_len    (skip_len),
        .launch      (launch),
        .busy        (busy),
        .done        (done),
        .tmo         (tmo),
        .rx_count    (rx_count),
        .err_total   (err_total),
        .err_payload (err_payload)
    );

    // Purpose: pack the status word at its fixed bit positions.
    always_comb begin
        status_word               = '0;
        status_word[ST_START_LVL] = ctrl_sync[0];
        status_word[ST_BUSY]      = busy;
        status_word[ST_DONE]      = done;
        status_word[ST_TIMEOUT]   = tmo;
    end

    assign signature = BBC_SIGNATURE;
endmodule

// File: rtl/ber_burst_ctrl_chk.sv
// Module: property checker for ber_burst_ctrl, attached through bind.
// Assumes: run parameters are stable while a run is active.
module ber_burst_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       status_word,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] err_total,
    input logic [CNT_W-1:0] err_payload,
    input logic [CNT_W-1:0] frame_len
);
    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(status_word[1]) |-> status_word[2]); // R4
    AST_TMO_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n) status_word[3] |-> status_word[2]); // R6
    AST_RX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) status_word[1] |-> (rx_count <= frame_len)); // R4
    AST_PAYLOAD_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n) err_payload <= err_total); // R5
    AST_TOTAL_LE_RX: assert property (@(posedge clk) disable iff (!rst_n) err_total <= rx_count); // R5
    AST_LAUNCH_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) $rose(status_word[1]) |-> (rx_count == '0 && err_total == '0 && !status_word[2])); // R8
    AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n) status_word[1] |=> (rx_count == $past(rx_count) || rx_count == CNT_W'($past(rx_count) + 1'b1))); // R3
endmodule

bind ber_burst_ctrl ber_burst_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_word (status_word),
    .rx_count    (rx_count),
    .err_total   (err_total),
    .err_payload (err_payload),
    .frame_len   (frame_len)
);

// File: tb/sim_ber_burst_ctrl.sv
// Bench: table-driven runs followed by directed corner cases.
module sim_ber_burst_ctrl;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ctrl_word = '0;
    logic [CNT_W-1:0] frame_len = '0;
    logic [CNT_W-1:0] pre_len = '0;
    logic [CNT_W-1:0] skip_len = '0;
    logic             bit_valid = 1'b0;
    logic             bit_data = 1'b0;
    logic             ref_bit = 1'b0;
    logic [3:0]       status_word;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] err_total;
    logic [CNT_W-1:0] err_payload;
    logic [31:0]      signature;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ber_burst_ctrl #(.CNT_W(CNT_W), .TIMEOUT_CYCLES(64)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .frame_len(frame_len), .pre_len(pre_len), .skip_len(skip_len),
        .bit_valid(bit_valid), .bit_data(bit_data), .ref_bit(ref_bit),
        .status_word(status_word), .rx_count(rx_count), .err_total(err_total),
        .err_payload(err_payload), .signature(signature)
    );

    // Vector fields: skip[87:80], preamble[79:72], frame[71:64], error mask[63:0]
    localparam logic [87:0] VECS [0:4] = '{
        {8'd0, 8'd0,  8'd8,  64'h0},
        {8'd3, 8'd4,  8'd10, 64'h0000_0000_0000_0203},
        {8'd5, 8'd25, 8'd40, 64'h0000_0080_0300_0000},
        {8'd2, 8'd16, 8'd16, 64'h0000_0000_0000_FFFF},
        {8'd1, 8'd0,  8'd64, 64'hAAAA_AAAA_AAAA_AAAA}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic err, input int idx);
        @(negedge clk);
        ref_bit   = idx[0] ^ idx[2];
        bit_data  = ref_bit ^ err;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk);
        ctrl_word[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy after start edge", 32'(status_word[1]), 32'd1);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R10 status after reset", 32'(status_word), 32'd0);
        chk("R10 rx after reset", 32'(rx_count), 32'd0);
        chk("R10 total after reset", 32'(err_total), 32'd0);
        chk("R10 payload after reset", 32'(err_payload), 32'd0);
        chk("R9 signature", signature, 32'h4250534B);

        // Table walk: R3, R4, R5
        for (int v = 0; v < 5; v++) begin
            int sk, pr, fr, exp_t, exp_p;
            logic [63:0] m;
            sk = int'(VECS[v][87:80]);
            pr = int'(VECS[v][79:72]);
            fr = int'(VECS[v][71:64]);
            m  = VECS[v][63:0];
            exp_t = 0; exp_p = 0;
            for (int i = 0; i < fr; i++) begin
                if (m[i]) begin
                    exp_t++;
                    if (i >= pr) exp_p++;
                end
            end
            skip_len  = CNT_W'(sk);
            pre_len   = CNT_W'(pr);
            frame_len = CNT_W'(fr);
            do_start();
            ctrl_word[0] = 1'b0;
            for (int i = 0; i < sk; i++) send_bit(1'b1, i);
            for (int i = 0; i < fr; i++) send_bit(m[i], i);
            wait_cyc(2);
            chk("R4 done after frame", 32'(status_word[3:1]), 32'b010);
            chk("R4 rx count", 32'(rx_count), 32'(fr));
            chk("R3/R5 total errors", 32'(err_total), 32'(exp_t));
            chk("R5 payload errors", 32'(err_payload), 32'(exp_p));
            send_bit(1'b1, 0);
            send_bit(1'b1, 1);
            chk("R4 bits after end ignored", 32'(rx_count), 32'(fr));
            chk("R4 errors after end ignored", 32'(err_total), 32'(exp_t));
        end

        // R8: start edge mid-run ignored
        skip_len = '0; pre_len = '0; frame_len = CNT_W'(10);
        do_start();
        ctrl_word[0] = 1'b0;
        for (int i = 0; i < 5; i++) send_bit(1'b0, i);
        wait_cyc(3);
        ctrl_word[0] = 1'b1;
        wait_cyc(4);
        ctrl_word[0] = 1'b0;
        wait_cyc(3);
        chk("R8 restart while busy ignored", 32'(rx_count), 32'd5);
        for (int i = 0; i < 5; i++) send_bit(1'b0, i);
        wait_cyc(2);
        chk("R8 run completes full frame", 32'(rx_count), 32'd10);
        chk("R8 done set", 32'(status_word[2]), 32'd1);

        // R1/R2/R7: held level does not relaunch; clear drops done
        frame_len = CNT_W'(4);
        do_start();
        for (int i = 0; i < 4; i++) send_bit(1'b0, i);
        wait_cyc(2);
        chk("R2 status with start held", 32'(status_word), 32'b0101);
        ctrl_word[1] = 1'b1;
        wait_cyc(4);
        ctrl_word[1] = 1'b0;
        wait_cyc(4);
        chk("R1/R7 held start no relaunch, done cleared", 32'(status_word), 32'b0001);
        ctrl_word[0] = 1'b0;
        wait_cyc(3);

        // R6: timeout abort
        frame_len = CNT_W'(20);
        do_start();
        ctrl_word[0] = 1'b0;
        for (int i = 0; i < 3; i++) send_bit(1'b1, i);
        wait_cyc(50);
        chk("R6 still busy before limit", 32'(status_word[3:1]), 32'b001);
        wait_cyc(30);
        chk("R6 abort flags", 32'(status_word[3:1]), 32'b110);
        chk("R6 rx count kept", 32'(rx_count), 32'd3);

        // R7: clear both sticky flags
        ctrl_word[1] = 1'b1;
        wait_cyc(4);
        ctrl_word[1] = 1'b0;
        wait_cyc(3);
        chk("R7 clear sticky flags", 32'(status_word[3:1]), 32'b000);
        chk("R7 rx untouched by clear", 32'(rx_count), 32'd3);

        // R8: accepted start zeroes counters
        do_start();
        ctrl_word[0] = 1'b0;
        chk("R8 counters zeroed on start", 32'(rx_count), 32'd0);
        chk("R8 errors zeroed on start", 32'(err_total), 32'd0);
        wait_cyc(80);
        chk("R6 second abort", 32'(status_word[3:1]), 32'b110);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule